// File: doc/BRIEF.md
# SMBus Host Controller with Byte-Handshaked Block Transfers

This block is a bus master for the System Management Bus. A processor programs it through eight byte-wide registers: it loads a target address with a direction bit, a command byte and data bytes, then writes the control register to start one transaction of the selected protocol. The controller generates START, repeated START and STOP conditions, shifts bytes out and in on open-drain SCL and SDA, checks the target's acknowledge, and reports the outcome in a status register whose flags are cleared by writing one.

Three protocol families are supported. The single-byte form sends or receives one byte with no command phase. The byte-data form writes or reads one byte at a command. The block form carries a count byte followed by that many payload bytes. Block payload passes through one block-data register, and software paces it byte by byte. After each byte the controller raises a byte-done flag and holds SCL low until software clears that flag. A status bit also serves as an ownership semaphore between software agents. A kill command abandons the current transfer at once.

Top module: `smbus_host`

## Requirements
- R1: After reset every register reads 0x00 and both SCL and SDA are released (`scl_oe` and `sda_oe` are 0). While no transaction is active, both lines stay released.
- R2: Status is at offset 0. Bit 0 is busy, bit 1 is done, bit 2 is device error, bit 6 is in-use and bit 7 is byte-done. Writing 1 to bits 1, 2, 6 or 7 clears that bit. A status read that returns in-use as 0 sets in-use to 1 from the next cycle on.
- R3: A write to control (offset 2) with bit 6 set starts a transaction only when busy is 0 and bits 4:2 hold 001 (single byte), 010 (byte data) or 101 (block). Busy then reads 1 from the next cycle on. Any other code starts nothing.
- R4: Write forms: single byte sends START, the address register (offset 4) and the command byte (offset 3), then STOP. Byte data sends START, the address with bit 0 forced to 0, the command, data byte 0 (offset 5), then STOP. At the end busy is 0 and done is 1.
- R5: Read forms: single byte sends START and the address (bit 0 = 1), then reads one byte. Byte data sends START, the address with bit 0 = 0, the command, a repeated START and the address with bit 0 = 1, then reads one byte. The read byte is placed in data byte 0 and acknowledged with NACK before STOP.
- R6: Block write (bit 0 of the address is 0) sends the command, then the count from data byte 0, then payload bytes taken from block data (offset 7). After each payload byte, byte-done is set and SCL is held low until software clears byte-done. The next byte is read from block data when byte-done is cleared.
- R7: Block read (bit 0 of the address is 1) uses a repeated START. When the first byte-done is raised, data byte 0 holds the received count. Each later byte-done presents the next received byte in block data. The final byte is NACKed.
- R8: A missing acknowledge on any byte sent by the controller sets device error, ends the transfer with STOP and clears busy. Done stays 0.
- R9: A control write with bit 1 set returns the controller to idle in the next cycle. Busy reads 0 and both lines are released.
- R10: SCL stays high for 2·DIV clock cycles per bit. SDA changes only while SCL is low, except at START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (affects only the in-use bit) |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench pairs the controller with a behavioural target that counts START and STOP conditions and records the last acknowledge the host sends. A byte-data read that drops its repeated START shows one START instead of two. A host that acknowledges its last read byte leaves the recorded bit at 0. The block tests stall on purpose at each byte-done and check that SCL stays low through the stall. A controller that runs ahead stores the wrong payload in the target, or returns a stale block-data byte. Further tests address an absent device, issue an unsupported protocol code and kill a stalled block transfer. A design that reports success on a NACK, starts on a bad code, or leaves a line pulled after the kill fails its check.

// File: rtl/smbus_host.sv
module smbus_host #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [3:0] {IDLE, START, ADDR, CMD, RSTART, ADDRR, WDATA, RDATA, WAIT, STOP} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh, rem, cmd, sadr, d0, d1, blk;
  logic [2:0] proto;
  logic nak, okf, cntph, done_f, err_f, inuse, bdone;

  logic busy, in_byte, rd_byte, blkp, rdir, tick, wr_ctl, kill, go, last_rd;
  assign busy    = (st != IDLE);
  assign in_byte = st inside {ADDR, CMD, ADDRR, WDATA, RDATA};
  assign rd_byte = (st == RDATA);
  assign blkp    = (proto == 3'b101);
  assign rdir    = sadr[0];
  assign tick    = (cnt == CW'(DIV - 1));
  assign wr_ctl  = reg_wr && (reg_addr == 3'd2);
  assign kill    = wr_ctl && reg_wdata[1];
  assign go      = wr_ctl && reg_wdata[6] && !busy &&
                   (reg_wdata[4:2] inside {3'b001, 3'b010, 3'b101});
  assign last_rd = !blkp || (cntph ? (sh == 8'd0) : (rem == 8'd1));

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      IDLE: ;
      START, RSTART: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = q[1];
      end
      STOP: begin
        scl_oe = (q == 2'd0);
        sda_oe = !q[1];
      end
      WAIT: scl_oe = 1'b1;
      default: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = (bitn == 4'd8) ? (rd_byte && !last_rd) : (!rd_byte && !sh[7]);
      end
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {bdone, inuse, 3'b000, err_f, done_f, busy};
      3'd2:    reg_rdata = {3'b000, proto, 2'b00};
      3'd3:    reg_rdata = cmd;
      3'd4:    reg_rdata = sadr;
      3'd5:    reg_rdata = d0;
      3'd6:    reg_rdata = d1;
      3'd7:    reg_rdata = blk;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; q <= '0; bitn <= '0; sh <= '0; rem <= '0;
      cmd <= '0; sadr <= '0; d0 <= '0; d1 <= '0; blk <= '0; proto <= '0;
      nak <= 1'b0; okf <= 1'b0; cntph <= 1'b0;
      done_f <= 1'b0; err_f <= 1'b0; inuse <= 1'b0; bdone <= 1'b0;
    end else begin
      if (reg_rd && reg_addr == 3'd0 && !inuse) inuse <= 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            if (reg_wdata[1]) done_f <= 1'b0;
            if (reg_wdata[2]) err_f  <= 1'b0;
            if (reg_wdata[6]) inuse  <= 1'b0;
            if (reg_wdata[7]) bdone  <= 1'b0;
          end
          3'd2: if (!busy) proto <= reg_wdata[4:2];
          3'd3: cmd  <= reg_wdata;
          3'd4: sadr <= reg_wdata;
          3'd5: d0   <= reg_wdata;
          3'd6: d1   <= reg_wdata;
          3'd7: blk  <= reg_wdata;
          default: ;
        endcase
      end

      if (kill) begin
        st <= IDLE;
      end else if (go) begin
        st <= START; cnt <= '0; q <= '0; bitn <= '0; okf <= 1'b1; cntph <= 1'b0;
      end else if (st == WAIT) begin
        if (!bdone) begin
          if (rem == 8'd0) st <= STOP;
          else if (rdir) st <= RDATA;
          else begin st <= WDATA; sh <= blk; end
        end
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd2 && in_byte && bitn != 4'd8 && rd_byte) sh <= {sh[6:0], sda_i};
          if (q == 2'd2 && in_byte && bitn == 4'd8) nak <= sda_i;
          if (q == 2'd3) begin
            if (in_byte && bitn != 4'd8) begin
              bitn <= bitn + 4'd1;
              if (!rd_byte) sh <= {sh[6:0], 1'b0};
            end else begin
              bitn <= '0;
              case (st)
                START: begin
                  st <= ADDR;
                  sh <= (proto == 3'b001) ? sadr : {sadr[7:1], 1'b0};
                end
                RSTART: begin st <= ADDRR; sh <= {sadr[7:1], 1'b1}; end
                ADDR:
                  if (nak) begin err_f <= 1'b1; okf <= 1'b0; st <= STOP; end
                  else if (proto == 3'b001) begin
                    if (rdir) st <= RDATA;
                    else begin st <= WDATA; sh <= cmd; end
                  end else begin st <= CMD; sh <= cmd; end
                CMD:
                  if (nak) begin err_f <= 1'b1; okf <= 1'b0; st <= STOP; end
                  else if (rdir) st <= RSTART;
                  else begin st <= WDATA; sh <= d0; cntph <= blkp; end
                ADDRR:
                  if (nak) begin err_f <= 1'b1; okf <= 1'b0; st <= STOP; end
                  else begin st <= RDATA; cntph <= blkp; end
                WDATA:
                  if (nak) begin err_f <= 1'b1; okf <= 1'b0; st <= STOP; end
                  else if (!blkp) st <= STOP;
                  else if (cntph) begin
                    cntph <= 1'b0;
                    rem <= d0;
                    if (d0 == 8'd0) st <= STOP;
                    else sh <= blk;
                  end else begin
                    rem <= rem - 8'd1; bdone <= 1'b1; st <= WAIT;
                  end
                RDATA:
                  if (!blkp) begin d0 <= sh; st <= STOP; end
                  else if (cntph) begin
                    cntph <= 1'b0; d0 <= sh; rem <= sh;
                    if (sh == 8'd0) st <= STOP;
                    else begin bdone <= 1'b1; st <= WAIT; end
                  end else begin
                    blk <= sh; rem <= rem - 8'd1; bdone <= 1'b1; st <= WAIT;
                  end
                STOP: begin st <= IDLE; if (okf) done_f <= 1'b1; end
                default: st <= IDLE;
              endcase
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       bdone,
  input logic       done_f,
  input logic       in_byte
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 3'd2 && reg_wdata[6]));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> (!busy && $past(busy)));

  // R6
  hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bdone) |-> scl_oe);

  // R9
  kill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 3'd2 && reg_wdata[1]) |-> !busy);

  // R10
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));
endmodule

bind smbus_host smbus_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
  .bdone(bdone), .done_f(done_f), .in_byte(in_byte)
);

// File: tb/smbus_host_tb.sv
module smbus_host_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  wire  [7:0] reg_rdata;
  wire  scl_oe, sda_oe;
  logic s_drv = 1'b0;
  wire  scl = ~scl_oe;
  wire  sda = ~(sda_oe | s_drv);

  smbus_host #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // target model at 7-bit address 0x50
  logic [7:0] mem [64];
  int starts = 0, stops = 0, s_bit = 0;
  logic s_act = 0, s_skip = 0, s_adph = 0, s_tx = 0, s_txon = 0, s_first = 0, mack = 0;
  logic [7:0] s_sh = '0, s_tb = '0;
  logic [5:0] ptr = '0;

  always @(negedge sda) if (scl === 1'b1) begin
    starts++; s_act = 1; s_skip = 1; s_bit = 0; s_adph = 1; s_tx = 0; s_txon = 0; s_drv = 0;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    stops++; s_act = 0; s_drv = 0;
  end
  always @(posedge scl) if (s_act) begin
    if (s_bit < 8) begin
      if (!s_tx) s_sh = {s_sh[6:0], sda};
    end else if (s_tx) mack = sda;
  end
  always @(negedge scl) if (s_act) begin
    if (s_skip) s_skip = 0;
    else begin
      s_bit++;
      if (s_bit == 8) begin
        if (!s_tx) begin
          if (s_adph) begin
            if (s_sh[7:1] == 7'h50) s_drv = 1; else s_act = 0;
          end else begin
            s_drv = 1;
            if (s_first) begin ptr = s_sh[5:0]; s_first = 0; end
            else begin mem[ptr] = s_sh; ptr++; end
          end
        end else s_drv = 0;
      end else if (s_bit == 9) begin
        s_bit = 0; s_drv = 0;
        if (s_adph) begin s_adph = 0; s_tx = s_sh[0]; s_first = 1; s_txon = s_tx; end
        else if (s_tx && mack) s_txon = 0;
        if (s_txon) begin s_tb = mem[ptr]; ptr++; s_drv = ~s_tb[7]; end
      end else if (s_txon) s_drv = ~s_tb[7 - s_bit];
    end
  end

  int hi_cnt = 0, hi_len = 0;
  always @(posedge clk) begin
    if (scl) hi_cnt++;
    else begin
      if (hi_cnt != 0) hi_len = hi_cnt;
      hi_cnt = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin rd(3'd0, s); n++; end while (s[0] && n < 5000);
  endtask

  task automatic wait_bd();
    logic [7:0] s;
    int n = 0;
    do begin rd(3'd0, s); n++; end while (!s[7] && n < 5000);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 scl_oe after reset", scl_oe, 0);
    chk("R1 sda_oe after reset", sda_oe, 0);
    rd(3'd0, v); chk("R1 status reset", v, 8'h00);
    rd(3'd2, v); chk("R1 control reset", v, 8'h00);
    rd(3'd5, v); chk("R1 data0 reset", v, 8'h00);
    rd(3'd7, v); chk("R1 block reset", v, 8'h00);
    rd(3'd0, v); chk("R2 in-use taken by first read", v, 8'h40);
    wr(3'd0, 8'h40);
    rd(3'd0, v); chk("R2 in-use released by write 1", v, 8'h00);
  endtask

  task automatic t_write_byte();
    logic [7:0] v;
    int s0 = starts, p0 = stops;
    wr(3'd4, 8'hA0); wr(3'd3, 8'h03); wr(3'd5, 8'h5A); wr(3'd2, 8'h48);
    wait_idle();
    rd(3'd0, v); chk("R4 write byte status", v & 8'hBF, 8'h02);
    chk("R4 write byte stored", mem[3], 8'h5A);
    chk("R4 write byte starts", starts - s0, 1);
    chk("R4 write byte stops", stops - p0, 1);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_send_recv();
    logic [7:0] v;
    mem[7] = 8'h3C;
    wr(3'd4, 8'hA0); wr(3'd3, 8'h07); wr(3'd2, 8'h44);
    wait_idle();
    rd(3'd0, v); chk("R4 send byte done", v & 8'hBF, 8'h02);
    wr(3'd0, 8'hBF);
    wr(3'd4, 8'hA1); wr(3'd2, 8'h44);
    wait_idle();
    rd(3'd5, v); chk("R5 receive byte data", v, 8'h3C);
    chk("R5 receive byte final NACK", mack, 1);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_read_byte();
    logic [7:0] v;
    int s0 = starts;
    mack = 0;
    wr(3'd4, 8'hA1); wr(3'd3, 8'h03); wr(3'd5, 8'h00); wr(3'd2, 8'h48);
    wait_idle();
    rd(3'd5, v); chk("R5 read byte data", v, 8'h5A);
    chk("R5 repeated start count", starts - s0, 2);
    chk("R5 read byte NACK", mack, 1);
    rd(3'd0, v); chk("R5 read byte done", v & 8'hBF, 8'h02);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_block_write();
    logic [7:0] v;
    logic [7:0] pay [3] = '{8'h11, 8'h22, 8'h33};
    wr(3'd4, 8'hA0); wr(3'd3, 8'h10); wr(3'd5, 8'h03); wr(3'd7, pay[0]); wr(3'd2, 8'h54);
    for (int i = 0; i < 3; i++) begin
      wait_bd();
      repeat (40) @(negedge clk);
      chk("R6 SCL held during byte-done", scl_oe, 1);
      rd(3'd0, v); chk("R6 busy during stall", v[0], 1);
      if (i < 2) wr(3'd7, pay[i + 1]);
      wr(3'd0, 8'h80);
    end
    wait_idle();
    rd(3'd0, v); chk("R6 block write done", v & 8'hBF, 8'h02);
    chk("R6 count stored", mem[16], 3);
    chk("R6 payload 0", mem[17], 8'h11);
    chk("R6 payload 1", mem[18], 8'h22);
    chk("R6 payload 2", mem[19], 8'h33);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_block_read();
    logic [7:0] v;
    mem[32] = 8'h02; mem[33] = 8'hC1; mem[34] = 8'hC2;
    mack = 0;
    wr(3'd4, 8'hA1); wr(3'd3, 8'h20); wr(3'd2, 8'h54);
    wait_bd(); rd(3'd5, v); chk("R7 count in data0", v, 8'h02);
    wr(3'd0, 8'h80);
    wait_bd(); rd(3'd7, v); chk("R7 first byte", v, 8'hC1);
    wr(3'd0, 8'h80);
    wait_bd(); rd(3'd7, v); chk("R7 second byte", v, 8'hC2);
    wr(3'd0, 8'h80);
    wait_idle();
    rd(3'd0, v); chk("R7 block read done", v & 8'hBF, 8'h02);
    chk("R7 last byte NACK", mack, 1);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    int p0 = stops;
    wr(3'd4, 8'h88); wr(3'd3, 8'h01); wr(3'd2, 8'h48);
    wait_idle();
    rd(3'd0, v); chk("R8 device error, no done", v & 8'hBF, 8'h04);
    chk("R8 STOP after NACK", stops - p0, 1);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_start_rules();
    logic [7:0] v;
    wr(3'd4, 8'hA0); wr(3'd2, 8'h4C);
    repeat (5) @(negedge clk);
    rd(3'd0, v); chk("R3 unsupported code ignored", v[0], 0);
    chk("R3 bus idle after bad code", scl_oe, 0);
    wr(3'd2, 8'h48);
    rd(3'd0, v); chk("R3 busy after valid start", v[0], 1);
    wait_idle();
    chk("R10 SCL high time", hi_len, 2 * DIV);
    wr(3'd0, 8'hBF);
  endtask

  task automatic t_kill();
    logic [7:0] v;
    wr(3'd4, 8'hA0); wr(3'd3, 8'h28); wr(3'd5, 8'h04); wr(3'd7, 8'h99); wr(3'd2, 8'h54);
    wait_bd();
    wr(3'd2, 8'h02);
    chk("R9 SCL released after kill", scl_oe, 0);
    chk("R9 SDA released after kill", sda_oe, 0);
    rd(3'd0, v); chk("R9 busy clear after kill", v[0], 0);
    wr(3'd0, 8'hBF);
    rd(3'd0, v); chk("R9 status clear after cleanup", v & 8'hBF, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_byte();
    t_send_recv();
    t_read_byte();
    t_block_write();
    t_block_read();
    t_nack();
    t_start_rules();
    t_kill();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule